// File: doc/BRIEF.md
# Threshold Write-Burst DRAM Scheduler

This block sits between the request side of a memory controller and a single DRAM command channel. Reads are sent to the channel as soon as they arrive. Writes are not sent on arrival. They go into a 24-line holding buffer and stay there until enough of them have built up. When the buffer occupancy reaches a programmable threshold, the scheduler turns the bus around. It then issues every held write on consecutive cycles, in the order the writes arrived, and turns the bus back to reads. Collecting writes this way means the costly change of bus direction happens once per batch and not once per write.

A read whose address matches a held write is answered directly from the buffer with the newest matching line, so it never returns stale data and does not use the DRAM channel. Each change of direction is separated by a fixed idle penalty of four cycles. A full buffer stops the write port and forces a drain, even when the programmed threshold is higher.

The control is a four-state machine:
- `PH_READ`: reads flow, writes accumulate.
- `PH_TURN_TO_WR`: turnaround toward writes. It is entered from `PH_READ` when occupancy reaches the threshold.
- `PH_WRITE`: drain. It is left when the buffer is empty.
- `PH_TURN_TO_RD`: turnaround back to reads. It returns to `PH_READ` when the timer expires.

Top module: `wbs_burst_sched`

## Requirements
- R1: After reset, `cmd_valid` and `fwd_valid` are 0, `bus_dir` is 0 (read direction), and both `rd_ready` and `wr_ready` are 1.
- R2: An accepted write produces no write command while buffer occupancy stays below the effective threshold.
- R3: The effective threshold is `thr_cfg` when it lies in 1..24. A value of 0 or above 24 means 24. While in the read phase, occupancy at or above the effective threshold starts a drain, including when the threshold is lowered below the current occupancy.
- R4: A drain issues every held write on consecutive cycles, in arrival order, and keeps going until the buffer is empty. Writes accepted during the turnaround or the drain are included.
- R5: `cmd_write` is 1 for a write command and 0 for a read command. Every command carries `bus_dir` equal to `cmd_write`. Between the last command of one direction and the first command of the other, at least 4 cycles carry no command.
- R6: A read accepted in cycle t whose address is not held appears as a read command in cycle t+1. `rd_ready` is 1 only in the read phase while no drain is pending.
- R7: A read accepted in cycle t whose address is held gives `fwd_valid` in cycle t+1, with the data of the newest held write to that address, and issues no command. A write accepted in the same cycle is not seen by that read.
- R8: `wr_ready` is 0 whenever the buffer holds 24 lines, and the full condition alone starts a drain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_cfg | input | 5 | Write-batch threshold; 0 or over 24 selects 24 |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | 32 | Read line address |
| rd_ready | output | 1 | Read request accepted this cycle |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | 32 | Write line address |
| wr_data | input | 128 | Write line data |
| wr_ready | output | 1 | Write request accepted this cycle |
| cmd_valid | output | 1 | DRAM command issued |
| cmd_write | output | 1 | 1 = write command, 0 = read command |
| cmd_addr | output | 32 | Command line address |
| cmd_wdata | output | 128 | Write data of a write command, 0 for reads |
| bus_dir | output | 1 | Current bus direction, 1 = write |
| fwd_valid | output | 1 | Read answered from the write buffer |
| fwd_data | output | 128 | Forwarded line data |

## Verification
The hardest condition to reach from the ports is a full buffer under a threshold that does not trigger. The bench programs a threshold of 0, which means 24, and also 31. It then feeds enough distinct writes to reach, or stay just short of, the full condition, and watches `wr_ready` and the write commands. Forwarding of the newest line is set up by rewriting an address that is already held before reading it back. Writes that arrive during a turnaround are placed directly after the threshold crossing. A long random mix over a small address set then repeats these cases many times, and a scoreboard queue tracks what is held at each read.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic [1:0] {
        PH_READ       = 2'd0,
        PH_TURN_TO_WR = 2'd1,
        PH_WRITE      = 2'd2,
        PH_TURN_TO_RD = 2'd3
    } phase_e;

endpackage

// File: rtl/wbs_line_buffer.sv
// Circular buffer of pending write lines with a full associative lookup
// that returns the youngest matching entry.
module wbs_line_buffer #(
    parameter int DEPTH  = 24,
    parameter int ADDR_W = 32,
    parameter int LINE_W = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [ADDR_W-1:0]            push_addr,
    input  logic [LINE_W-1:0]            push_data,
    input  logic                         pop,
    input  logic [ADDR_W-1:0]            look_addr,
    output logic                         look_hit,
    output logic [LINE_W-1:0]            look_data,
    output logic [ADDR_W-1:0]            head_addr,
    output logic [LINE_W-1:0]            head_data,
    output logic [$clog2(DEPTH+1)-1:0]   occ,
    output logic                         full,
    output logic                         empty
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [LINE_W-1:0] data_mem [DEPTH];
    logic [IDX_W-1:0]  head_q, tail_q;
    logic [OCC_W-1:0]  occ_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(DEPTH - 1)) ? '0 : idx + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[tail_q] <= push_addr;
            data_mem[tail_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (push) tail_q <= step(tail_q);
            if (pop)  head_q <= step(head_q);
            unique case ({push, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // Walk entries from oldest to youngest; a later match overrides.
    always_comb begin
        look_hit  = 1'b0;
        look_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int unsigned slot;
            logic [IDX_W-1:0] idx;
            slot = int'(head_q) + i;
            if (slot >= DEPTH) slot = slot - DEPTH;
            idx = IDX_W'(slot);
            if (OCC_W'(i) < occ_q && addr_mem[idx] == look_addr) begin
                look_hit  = 1'b1;
                look_data = data_mem[idx];
            end
        end
    end

    assign head_addr = addr_mem[head_q];
    assign head_data = data_mem[head_q];
    assign occ       = occ_q;
    assign full      = (occ_q == OCC_W'(DEPTH));
    assign empty     = (occ_q == '0);

endmodule

// File: rtl/wbs_turn_timer.sv
// Counts the idle cycles of a bus turnaround; done while the count is zero.
module wbs_turn_timer #(
    parameter int TURN_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CNT_W = (TURN_CYC > 1) ? $clog2(TURN_CYC + 1) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(TURN_CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/wbs_phase_fsm.sv
module wbs_phase_fsm
    import wbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   drain_req,
    input  logic   buf_empty,
    input  logic   turn_done,
    output phase_e phase,
    output logic   turn_start,
    output logic   rd_open,
    output logic   wr_pop,
    output logic   dir_to_wr,
    output logic   dir_to_rd
);
    phase_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_READ;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_READ:       if (drain_req) state_d = PH_TURN_TO_WR;
            PH_TURN_TO_WR: if (turn_done) state_d = PH_WRITE;
            PH_WRITE:      if (buf_empty) state_d = PH_TURN_TO_RD;
            PH_TURN_TO_RD: if (turn_done) state_d = PH_READ;
            default:       state_d = PH_READ;
        endcase
    end

    always_comb begin
        turn_start = 1'b0;
        rd_open    = 1'b0;
        wr_pop     = 1'b0;
        dir_to_wr  = 1'b0;
        dir_to_rd  = 1'b0;
        unique case (state_q)
            PH_READ: begin
                rd_open    = !drain_req;
                turn_start = drain_req;
            end
            PH_TURN_TO_WR: dir_to_wr = turn_done;
            PH_WRITE: begin
                wr_pop     = !buf_empty;
                turn_start = buf_empty;
            end
            PH_TURN_TO_RD: dir_to_rd = turn_done;
            default: ;
        endcase
    end

    assign phase = state_q;

endmodule

// File: rtl/wbs_burst_sched.sv
module wbs_burst_sched
    import wbs_pkg::*;
#(
    parameter int DEPTH    = 24,
    parameter int ADDR_W   = 32,
    parameter int LINE_W   = 128,
    parameter int TURN_CYC = 4,
    localparam int OCC_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OCC_W-1:0]  thr_cfg,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LINE_W-1:0] cmd_wdata,
    output logic              bus_dir,
    output logic              fwd_valid,
    output logic [LINE_W-1:0] fwd_data
);
    logic [OCC_W-1:0]  occ, eff_thr;
    logic              full, empty, look_hit;
    logic [LINE_W-1:0] look_data, head_data;
    logic [ADDR_W-1:0] head_addr;
    logic              drain_req, turn_start, turn_done;
    logic              rd_open, wr_pop, dir_to_wr, dir_to_rd;
    logic              push, rd_take;
    phase_e            phase;

    always_comb begin
        if (thr_cfg == '0 || thr_cfg > OCC_W'(DEPTH)) eff_thr = OCC_W'(DEPTH);
        else                                          eff_thr = thr_cfg;
    end

    assign drain_req = (occ >= eff_thr) || full;
    assign wr_ready  = !full;
    assign push      = wr_valid && !full;
    assign rd_ready  = rd_open;
    assign rd_take   = rd_valid && rd_open;

    wbs_line_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (wr_pop),
        .look_addr (rd_addr),
        .look_hit  (look_hit),
        .look_data (look_data),
        .head_addr (head_addr),
        .head_data (head_data),
        .occ       (occ),
        .full      (full),
        .empty     (empty)
    );

    wbs_turn_timer #(.TURN_CYC(TURN_CYC)) u_turn (
        .clk   (clk),
        .rst_n (rst_n),
        .start (turn_start),
        .done  (turn_done)
    );

    wbs_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .drain_req  (drain_req),
        .buf_empty  (empty),
        .turn_done  (turn_done),
        .phase      (phase),
        .turn_start (turn_start),
        .rd_open    (rd_open),
        .wr_pop     (wr_pop),
        .dir_to_wr  (dir_to_wr),
        .dir_to_rd  (dir_to_rd)
    );

    // Registered command, forwarding and direction outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_write <= 1'b0;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
            bus_dir   <= 1'b0;
        end else begin
            cmd_valid <= (rd_take && !look_hit) || wr_pop;
            cmd_write <= wr_pop;
            cmd_addr  <= wr_pop ? head_addr : rd_addr;
            cmd_wdata <= wr_pop ? head_data : '0;
            fwd_valid <= rd_take && look_hit;
            fwd_data  <= look_data;
            if (dir_to_wr)      bus_dir <= 1'b1;
            else if (dir_to_rd) bus_dir <= 1'b0;
        end
    end

endmodule

// File: rtl/wbs_burst_sched_chk.sv
module wbs_burst_sched_chk
    import wbs_pkg::*;
#(
    parameter int DEPTH    = 24,
    parameter int TURN_CYC = 4,
    parameter int OCC_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_write,
    input logic             bus_dir,
    input logic             rd_ready,
    input logic             wr_ready,
    input logic             fwd_valid,
    input logic [OCC_W-1:0] occ,
    input logic [OCC_W-1:0] eff_thr,
    input phase_e           phase
);
    localparam int GAP_W = $clog2(TURN_CYC + 2);

    logic [GAP_W-1:0] idle_q;
    logic             last_dir_q, seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q     <= '0;
            last_dir_q <= 1'b0;
            seen_q     <= 1'b0;
        end else if (cmd_valid) begin
            idle_q     <= '0;
            last_dir_q <= cmd_write;
            seen_q     <= 1'b1;
        end else if (idle_q < GAP_W'(TURN_CYC)) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && seen_q && cmd_write != last_dir_q) |-> idle_q >= GAP_W'(TURN_CYC)); // R5
    AST_WR_CMD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write) |-> bus_dir); // R5
    AST_RD_CMD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |-> !bus_dir); // R5
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_W'(DEPTH)) |-> !wr_ready); // R8
    AST_DRAIN_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TURN_TO_WR && $past(phase) == PH_READ) |-> $past(occ) >= $past(eff_thr)); // R3
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && occ != '0) |=> (cmd_valid && cmd_write)); // R4
    AST_RD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !bus_dir); // R6
    AST_FWD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, cmd_valid})); // R7

endmodule

bind wbs_burst_sched wbs_burst_sched_chk #(
    .DEPTH(DEPTH), .TURN_CYC(TURN_CYC), .OCC_W(OCC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .bus_dir   (bus_dir),
    .rd_ready  (rd_ready),
    .wr_ready  (wr_ready),
    .fwd_valid (fwd_valid),
    .occ       (occ),
    .eff_thr   (eff_thr),
    .phase     (phase)
);

// File: tb/tb_wbs_burst_sched.sv
module tb_wbs_burst_sched;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   thr_cfg = 5'd5;
    logic         rd_valid = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic         rd_ready;
    logic         wr_valid = 1'b0;
    logic [31:0]  wr_addr = '0;
    logic [127:0] wr_data = '0;
    logic         wr_ready;
    logic         cmd_valid, cmd_write, bus_dir, fwd_valid;
    logic [31:0]  cmd_addr;
    logic [127:0] cmd_wdata, fwd_data;

    int n_chk = 0;
    int n_fail = 0;
    int wcmds = 0;
    int cur_run = 0;
    int last_run = 0;
    int idle = 0;
    bit have_last = 0;
    bit last_dir = 0;

    logic [31:0]  waddr_q[$];
    logic [127:0] wdata_q[$];
    logic [31:0]  miss_q[$];
    logic [127:0] hit_q[$];

    always #4 clk = ~clk;

    wbs_burst_sched dut (
        .clk(clk), .rst_n(rst_n), .thr_cfg(thr_cfg),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .bus_dir(bus_dir),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Driver: each task pushes what the scoreboard must later see.
    task automatic do_write(input logic [31:0] a, input logic [127:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        waddr_q.push_back(a);
        wdata_q.push_back(d);
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] a);
        bit hit;
        logic [127:0] hd;
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        while (!rd_ready) @(negedge clk);
        hit = 0; hd = '0;
        for (int i = 0; i < waddr_q.size(); i++)
            if (waddr_q[i] == a) begin hit = 1; hd = wdata_q[i]; end
        if (hit) hit_q.push_back(hd);
        else     miss_q.push_back(a);
        @(posedge clk); #1;
        rd_valid = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_drained();
        for (int i = 0; i < 3000 && waddr_q.size() != 0; i++) @(negedge clk);
        idle_cycles(4);
    endtask

    // Monitor: compares design output against queued expectations.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                if (cmd_valid) begin
                    chk(bus_dir == cmd_write, "R5", "bus_dir vs cmd_write", bus_dir, cmd_write);
                    if (have_last && cmd_write != last_dir)
                        chk(idle >= 4, "R5", "turnaround idle cycles", idle, 4);
                    have_last = 1; last_dir = cmd_write; idle = 0;
                    if (cmd_write) begin
                        wcmds++; cur_run++;
                        if (waddr_q.size() == 0) begin
                            chk(0, "R4", "unexpected write command", cmd_addr, 0);
                        end else begin
                            chk(cmd_addr == waddr_q[0], "R4", "write order addr", cmd_addr, waddr_q[0]);
                            chk(cmd_wdata == wdata_q[0], "R4", "write order data", cmd_wdata, wdata_q[0]);
                            void'(waddr_q.pop_front());
                            void'(wdata_q.pop_front());
                        end
                    end else begin
                        if (miss_q.size() == 0) begin
                            chk(0, "R6", "unexpected read command", cmd_addr, 0);
                        end else begin
                            chk(cmd_addr == miss_q[0], "R6", "read command addr", cmd_addr, miss_q[0]);
                            void'(miss_q.pop_front());
                        end
                    end
                end else begin
                    idle++;
                end
                if (!(cmd_valid && cmd_write) && cur_run > 0) begin
                    last_run = cur_run; cur_run = 0;
                end
                if (fwd_valid) begin
                    if (hit_q.size() == 0) begin
                        chk(0, "R7", "unexpected forward", fwd_data, 0);
                    end else begin
                        chk(fwd_data == hit_q[0], "R7", "forward data", fwd_data, hit_q[0]);
                        void'(hit_q.pop_front());
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid == 0, "R1", "cmd_valid after reset", cmd_valid, 0);
        chk(fwd_valid == 0, "R1", "fwd_valid after reset", fwd_valid, 0);
        chk(bus_dir == 0, "R1", "bus_dir after reset", bus_dir, 0);
        chk(rd_ready == 1 && wr_ready == 1, "R1", "ready after reset", {rd_ready, wr_ready}, 2'b11);

        // Threshold 5: buffering, forwarding, drain with a late write.
        thr_cfg = 5'd5;
        do_write(32'h100, 128'hA1);
        do_write(32'h140, 128'hA2);
        do_write(32'h180, 128'hA3);
        idle_cycles(20);
        chk(wcmds == 0, "R2", "no write below threshold", wcmds, 0);
        do_read(32'h1000);
        do_read(32'h140);
        do_write(32'h140, 128'hB4);
        do_read(32'h140);
        idle_cycles(3);
        chk(wcmds == 0, "R2", "still below threshold", wcmds, 0);
        do_write(32'h1C0, 128'hA5);
        @(negedge clk);
        chk(rd_ready == 0, "R6", "reads closed once drain pending", rd_ready, 0);
        do_write(32'h200, 128'hA6);
        do_read(32'h2000);
        wait_drained();
        chk(wcmds == 6, "R4", "all writes drained", wcmds, 6);
        chk(last_run == 6, "R4", "drain run length incl. late write", last_run, 6);

        // Threshold 0 selects 24: full buffer forces the drain.
        thr_cfg = 5'd0;
        base = wcmds;
        for (int i = 0; i < 23; i++) do_write(32'h4000 + i * 32'h40, 128'(32'hC000 + i));
        idle_cycles(30);
        chk(wcmds == base, "R3", "threshold 0 holds 23 lines", wcmds, base);
        do_write(32'h4000 + 23 * 32'h40, 128'hC0FF);
        @(negedge clk);
        chk(wr_ready == 0, "R8", "wr_ready low when full", wr_ready, 0);
        wait_drained();
        chk(wcmds == base + 24, "R8", "full buffer drained", wcmds, base + 24);
        chk(last_run == 24, "R4", "24 writes back to back", last_run, 24);
        chk(wr_ready == 1, "R8", "wr_ready back after drain", wr_ready, 1);

        // Threshold 31 clamps to 24; lowering it starts a drain.
        thr_cfg = 5'd31;
        base = wcmds;
        for (int i = 0; i < 10; i++) do_write(32'h6000 + i * 32'h40, 128'(32'hD000 + i));
        idle_cycles(20);
        chk(wcmds == base, "R3", "threshold 31 holds 10 lines", wcmds, base);
        @(negedge clk); thr_cfg = 5'd2;
        wait_drained();
        chk(last_run == 10, "R3", "lowered threshold drains", last_run, 10);

        // Random mix over a small address set.
        thr_cfg = 5'd6;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            a = 32'h8000 + ($urandom % 12) * 32'h40;
            if ($urandom % 2 == 0) do_write(a, {$urandom, $urandom, $urandom, $urandom});
            else                   do_read(a);
        end
        @(negedge clk); thr_cfg = 5'd1;
        wait_drained();
        idle_cycles(10);
        chk(waddr_q.size() == 0, "R4", "write queue empty", waddr_q.size(), 0);
        chk(miss_q.size() == 0, "R6", "read queue empty", miss_q.size(), 0);
        chk(hit_q.size() == 0, "R7", "forward queue empty", hit_q.size(), 0);
        summary();
        $finish;
    end

endmodule